// File: doc/BRIEF.md
# CAN Receive Queue Identifier Acceptance Filter

This block decides whether a frame that the CAN protocol engine has just received may enter the receive queue. It holds no storage of its own. It reads a table of eight 32-bit filter words, and each word has its own 32-bit mask word. A 2-bit format select sets how every filter word is read:

- as one extended-identifier filter;
- as two standard-identifier filters;
- as four 8-bit identifier-slice filters.

A fourth format value shuts the filter off. In each mask, a 1 bit means the received bit must equal the filter bit. A 0 bit means that bit is not compared. The masks cover the frame-type (IDE) and remote-request (RTR) flags as well as the identifier.

The receive engine presents the identifier, IDE and RTR together with a one-cycle frame-valid strobe. One clock later the block raises a one-cycle accept pulse. At the same edge it loads the number of the lowest matching sub-filter. In ascending order, the numbering runs through word 0 first. Inside a word it takes the most significant sub-filter first. The receive queue can store that number as its filter-hit tag.

Top module: `can_rxfifo_idfilt`

## Requirements
- R1: While reset is asserted, and after it is released until the first strobe, `acc_o` is 0 and `acc_idx_o` is 0.
- R2: `acc_o` is high only in the cycle after a cycle with `rx_valid_i` high. On each strobe, `acc_idx_o` loads the matching index, or 0 when the frame is rejected. Without a strobe, `acc_idx_o` holds its value and the received fields have no effect.
- R3: With format 2'b00, filter word e matches when its bit 31 (RTR), bit 30 (IDE) and bits 28:0 (identifier) equal the received RTR, IDE and key. The key is `rx_id_i[28:0]` for extended frames and {18 zeros, `rx_id_i[10:0]`} for standard frames. Bit 29 is never compared. The index is e.
- R4: Each filter word uses only its own mask word, at the same bit positions. A mask bit of 1 compares the bit and a mask bit of 0 ignores it.
- R5: IDE and RTR are compared like identifier bits. A filter with IDE=1 rejects a standard frame, and a filter with IDE=0 rejects an extended frame, unless the mask clears the IDE bit. The same rule applies to RTR.
- R6: With format 2'b01, sub-filter 0 is bits 31:16 and sub-filter 1 is bits 15:0. Inside each half, bit 15 is RTR, bit 14 is IDE, bits 10:0 are the identifier, and bits 13:11 are never compared. The identifier is compared with `rx_id_i[10:0]` for standard frames and with `rx_id_i[28:18]` for extended frames. The index is 2e+s.
- R7: With format 2'b10, sub-filter s is the byte at bits 31-8s down to 24-8s. The byte is compared with `rx_id_i[10:3]` for standard frames and with `rx_id_i[28:21]` for extended frames. IDE and RTR are not compared. The index is 4e+s.
- R8: With format 2'b11, every frame is rejected.
- R9: When several sub-filters match, the lowest index is reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| fmt_sel_i | input | 2 | Table format: 00 extended, 01 dual standard, 10 quad slice, 11 off |
| filt_tbl_i | input | 256 | Eight 32-bit filter words, word e at bits 32e+31:32e |
| mask_tbl_i | input | 256 | Eight 32-bit mask words, same layout as the filter words |
| rx_valid_i | input | 1 | One-cycle strobe marking a received frame |
| rx_id_i | input | 29 | Received identifier; standard identifiers sit in bits 10:0 |
| rx_ide_i | input | 1 | Received frame-type flag, 1 for an extended frame |
| rx_rtr_i | input | 1 | Received remote-request flag |
| acc_o | output | 1 | One-cycle accept pulse, one clock after the strobe |
| acc_idx_o | output | 5 | Index of the lowest matching sub-filter |

## Verification
Two functions can meet in one cycle: different sub-filters can match the same frame, and a new frame can arrive in the cycle right after the previous one. The bench programs overlapping entries, both across words and inside one word, so that a single strobe hits several sub-filters. It also sends frames on consecutive cycles without gaps. Each result is judged against an independent model that scans the sub-filters in ascending order. Random bursts with sparse masks make multiple hits common in every format. The monitor confirms that each result lands exactly one clock after its own strobe and is not mixed with the next frame's result.

// File: rtl/can_idf_pkg.sv
package can_idf_pkg;

  localparam int ELEM_W       = 32;
  localparam int EXT_ID_W     = 29;
  localparam int STD_ID_W     = 11;
  localparam int SLICE_W      = 8;
  localparam int SUB_PER_ELEM = 4;
  localparam int HALF_W       = ELEM_W / 2;

  typedef enum logic [1:0] {
    FMT_EXT   = 2'b00,
    FMT_STD   = 2'b01,
    FMT_SLICE = 2'b10,
    FMT_OFF   = 2'b11
  } fmt_e;

endpackage

// File: rtl/can_idf_elem.sv
module can_idf_elem
  import can_idf_pkg::*;
(
  input  fmt_e                      fmt_i,
  input  logic [ELEM_W-1:0]         filt_i,
  input  logic [ELEM_W-1:0]         mask_i,
  input  logic [EXT_ID_W-1:0]       id_i,
  input  logic                      ide_i,
  input  logic                      rtr_i,
  output logic [SUB_PER_ELEM-1:0]   hit_o
);

  localparam int EXT_CMP_W = EXT_ID_W + 2;
  localparam int STD_CMP_W = STD_ID_W + 2;

  logic [EXT_ID_W-1:0]   key_ext;
  logic [STD_ID_W-1:0]   key_std;
  logic [SLICE_W-1:0]    key_slc;
  logic [EXT_CMP_W-1:0]  ext_diff;
  logic                  ext_hit;
  logic [1:0]            std_hit;
  logic [3:0]            slc_hit;

  // received keys: standard ids live in the low bits, extended ids use the top
  always_comb begin
    key_ext = ide_i ? id_i : {{(EXT_ID_W-STD_ID_W){1'b0}}, id_i[STD_ID_W-1:0]};
    key_std = ide_i ? id_i[EXT_ID_W-1 -: STD_ID_W] : id_i[STD_ID_W-1:0];
    key_slc = ide_i ? id_i[EXT_ID_W-1 -: SLICE_W] : id_i[STD_ID_W-1 -: SLICE_W];
  end

  // one extended filter per word: bit 29 is left out of the compare
  always_comb begin
    ext_diff = ({filt_i[31:30], filt_i[EXT_ID_W-1:0]} ^ {rtr_i, ide_i, key_ext})
             & {mask_i[31:30], mask_i[EXT_ID_W-1:0]};
    ext_hit  = ~|ext_diff;
  end

  // two standard filters, sub 0 in the upper half
  always_comb begin
    for (int s = 0; s < 2; s++) begin
      logic [HALF_W-1:0]    half_f;
      logic [HALF_W-1:0]    half_m;
      logic [STD_CMP_W-1:0] half_d;
      half_f     = filt_i[HALF_W*(1-s) +: HALF_W];
      half_m     = mask_i[HALF_W*(1-s) +: HALF_W];
      half_d     = ({half_f[15:14], half_f[STD_ID_W-1:0]} ^ {rtr_i, ide_i, key_std})
                 & {half_m[15:14], half_m[STD_ID_W-1:0]};
      std_hit[s] = ~|half_d;
    end
  end

  // four slice filters, sub 0 in the top byte
  always_comb begin
    for (int s = 0; s < 4; s++) begin
      slc_hit[s] = ~|((filt_i[SLICE_W*(3-s) +: SLICE_W] ^ key_slc)
                      & mask_i[SLICE_W*(3-s) +: SLICE_W]);
    end
  end

  always_comb begin
    unique case (fmt_i)
      FMT_EXT:   hit_o = {3'b000, ext_hit};
      FMT_STD:   hit_o = {2'b00, std_hit};
      FMT_SLICE: hit_o = slc_hit;
      default:   hit_o = '0;
    endcase
  end

endmodule

// File: rtl/can_idf_prio.sv
module can_idf_prio #(
  parameter int NUM_SUB = 32,
  localparam int IDX_W  = $clog2(NUM_SUB)
) (
  input  logic [NUM_SUB-1:0] hit_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);

  // lowest set bit wins: scan from the top so the last write is the lowest
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = NUM_SUB-1; i >= 0; i--) begin
      if (hit_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/can_rxfifo_idfilt.sv
module can_rxfifo_idfilt
  import can_idf_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  localparam int NUM_SUB    = NUM_ENTRIES * SUB_PER_ELEM,
  localparam int IDX_W      = $clog2(NUM_SUB),
  localparam int TBL_W      = NUM_ENTRIES * ELEM_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           fmt_sel_i,
  input  logic [TBL_W-1:0]     filt_tbl_i,
  input  logic [TBL_W-1:0]     mask_tbl_i,
  input  logic                 rx_valid_i,
  input  logic [EXT_ID_W-1:0]  rx_id_i,
  input  logic                 rx_ide_i,
  input  logic                 rx_rtr_i,
  output logic                 acc_o,
  output logic [IDX_W-1:0]     acc_idx_o
);

  fmt_e                    fmt;
  logic [SUB_PER_ELEM-1:0] ent_hit [NUM_ENTRIES];
  logic [NUM_SUB-1:0]      hit_vec;
  logic                    any_hit;
  logic [IDX_W-1:0]        enc_idx;
  logic                    acc_d, acc_q;
  logic [IDX_W-1:0]        idx_d, idx_q;
  logic                    idx_en;

  assign fmt = fmt_e'(fmt_sel_i);

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_elem
    can_idf_elem u_elem (
      .fmt_i  (fmt),
      .filt_i (filt_tbl_i[ELEM_W*e +: ELEM_W]),
      .mask_i (mask_tbl_i[ELEM_W*e +: ELEM_W]),
      .id_i   (rx_id_i),
      .ide_i  (rx_ide_i),
      .rtr_i  (rx_rtr_i),
      .hit_o  (ent_hit[e])
    );
  end

  // flatten per-word hits into one vector ordered by reported index
  always_comb begin
    hit_vec = '0;
    unique case (fmt)
      FMT_EXT: begin
        for (int e = 0; e < NUM_ENTRIES; e++) hit_vec[e] = ent_hit[e][0];
      end
      FMT_STD: begin
        for (int e = 0; e < NUM_ENTRIES; e++)
          for (int s = 0; s < 2; s++) hit_vec[2*e+s] = ent_hit[e][s];
      end
      FMT_SLICE: begin
        for (int e = 0; e < NUM_ENTRIES; e++)
          for (int s = 0; s < SUB_PER_ELEM; s++)
            hit_vec[SUB_PER_ELEM*e+s] = ent_hit[e][s];
      end
      default: hit_vec = '0;
    endcase
  end

  can_idf_prio #(.NUM_SUB(NUM_SUB)) u_prio (
    .hit_i (hit_vec),
    .any_o (any_hit),
    .idx_o (enc_idx)
  );

  // next state
  always_comb begin
    idx_en = rx_valid_i;
    acc_d  = rx_valid_i & any_hit;
    idx_d  = any_hit ? enc_idx : '0;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= 1'b0;
      idx_q <= '0;
    end else begin
      acc_q <= acc_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  assign acc_o     = acc_q;
  assign acc_idx_o = idx_q;

  // assertion support: no set hit below the encoded index
  logic lower_clr;
  always_comb begin
    lower_clr = 1'b1;
    for (int j = 0; j < NUM_SUB; j++)
      if ((j < int'(enc_idx)) && hit_vec[j]) lower_clr = 1'b0;
  end

  AST_ACC_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o |-> $past(rx_valid_i)); // R2

  AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> $stable(acc_idx_o)); // R2

  AST_OFF_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && fmt_sel_i == 2'b11) |=> !acc_o); // R8

  AST_EXT_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && fmt_sel_i == 2'b00) |=> (acc_idx_o < IDX_W'(NUM_ENTRIES))); // R3

  AST_STD_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && fmt_sel_i == 2'b01) |=> (acc_idx_o < IDX_W'(2*NUM_ENTRIES))); // R6

  AST_PRIO_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_hit |-> (hit_vec[enc_idx] && lower_clr)); // R9

endmodule

// File: tb/can_rxfifo_idfilt_tb_top.sv
`timescale 1ns/1ps
module can_rxfifo_idfilt_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   fmt_sel = 2'b00;
  logic [31:0]  filt [8];
  logic [31:0]  msk  [8];
  logic [255:0] filt_flat, msk_flat;
  logic         rx_valid = 1'b0;
  logic [28:0]  rx_id = '0;
  logic         rx_ide = 1'b0;
  logic         rx_rtr = 1'b0;
  logic         acc_o;
  logic [4:0]   idx_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [4:0] last_idx = '0;
  logic [5:0] q_exp [$];
  string      q_tag [$];

  always #2.5 clk = ~clk;

  always_comb begin
    for (int g = 0; g < 8; g++) begin
      filt_flat[32*g +: 32] = filt[g];
      msk_flat[32*g +: 32]  = msk[g];
    end
  end

  can_rxfifo_idfilt dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .fmt_sel_i  (fmt_sel),
    .filt_tbl_i (filt_flat),
    .mask_tbl_i (msk_flat),
    .rx_valid_i (rx_valid),
    .rx_id_i    (rx_id),
    .rx_ide_i   (rx_ide),
    .rx_rtr_i   (rx_rtr),
    .acc_o      (acc_o),
    .acc_idx_o  (idx_o)
  );

  // independent reference: walk indices upward, decode word/sub, compare bit by bit
  function automatic logic [5:0] model(input logic [28:0] id, input logic ide, input logic rtr);
    int per;
    per = (fmt_sel == 2'd0) ? 1 : (fmt_sel == 2'd1) ? 2 : (fmt_sel == 2'd2) ? 4 : 0;
    if (per == 0) return 6'd0;
    for (int i = 0; i < 8*per; i++) begin
      int e, s, off;
      logic ok;
      logic [31:0] f, m;
      e = i / per; s = i % per;
      f = filt[e]; m = msk[e];
      ok = 1'b1;
      if (per == 1) begin
        if (m[31] && f[31] != rtr) ok = 1'b0;
        if (m[30] && f[30] != ide) ok = 1'b0;
        for (int b = 0; b < 29; b++) begin
          logic kb;
          kb = ide ? id[b] : ((b < 11) ? id[b] : 1'b0);
          if (m[b] && f[b] != kb) ok = 1'b0;
        end
      end else if (per == 2) begin
        off = (s == 0) ? 16 : 0;
        if (m[off+15] && f[off+15] != rtr) ok = 1'b0;
        if (m[off+14] && f[off+14] != ide) ok = 1'b0;
        for (int b = 0; b < 11; b++) begin
          logic kb;
          kb = ide ? id[18+b] : id[b];
          if (m[off+b] && f[off+b] != kb) ok = 1'b0;
        end
      end else begin
        off = 24 - 8*s;
        for (int b = 0; b < 8; b++) begin
          logic kb;
          kb = ide ? id[21+b] : id[3+b];
          if (m[off+b] && f[off+b] != kb) ok = 1'b0;
        end
      end
      if (ok) return {1'b1, 5'(i)};
    end
    return 6'd0;
  endfunction

  task automatic send(input logic [28:0] id, input logic ide, input logic rtr, input string tag);
    logic [5:0] e;
    @(negedge clk);
    rx_valid = 1'b1; rx_id = id; rx_ide = ide; rx_rtr = rtr;
    e = model(id, ide, rtr);
    @(posedge clk);
    q_exp.push_back(e);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_valid = 1'b0;
    end
  endtask

  task automatic clear_table();
    for (int k = 0; k < 8; k++) begin
      filt[k] = 32'hFFFF_FFFF;
      msk[k]  = 32'hFFFF_FFFF;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (q_exp.size() > 0) begin
        logic [5:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        checks++;
        if ({acc_o, idx_o} !== e) begin
          errors++;
          $display("FAIL %s: acc=%0b idx=%0d expected acc=%0b idx=%0d",
                   t, acc_o, idx_o, e[5], e[4:0]);
        end
      end else begin
        checks++;
        if (acc_o !== 1'b0 || idx_o !== last_idx) begin
          errors++;
          $display("FAIL R2 idle: acc=%0b idx=%0d expected acc=0 idx=%0d",
                   acc_o, idx_o, last_idx);
        end
      end
      last_idx = idx_o;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_table();
    repeat (4) @(negedge clk);
    checks++;
    if (acc_o !== 1'b0 || idx_o !== 5'd0) begin
      errors++;
      $display("FAIL R1: acc=%0b idx=%0d expected acc=0 idx=0", acc_o, idx_o);
    end
    rst_n = 1'b1;
    idle(3);

    // R3: exact extended match in word 3
    fmt_sel = 2'b00;
    filt[3] = 32'h4123_4567;
    send(29'h0123_4567, 1'b1, 1'b0, "R3 ext exact");
    // R2: matching fields without a strobe must not accept
    idle(1);
    rx_id = 29'h0123_4567; rx_ide = 1'b1;
    idle(3);
    // R5: RTR differs under full mask
    send(29'h0123_4567, 1'b1, 1'b1, "R5 rtr mismatch");
    // R4: partial mask in word 5
    filt[5] = 32'h4000_AB00; msk[5] = 32'hC000_FF00;
    idle(1);
    send(29'h01FF_AB77, 1'b1, 1'b0, "R4 masked match");
    send(29'h0000_AC00, 1'b1, 1'b0, "R4 masked mismatch");
    // R5: extended filter vs standard frame, then IDE masked off
    idle(1);
    filt[2] = 32'h4000_0123;
    send(29'h0000_0123, 1'b0, 1'b0, "R5 ide mismatch");
    idle(1);
    msk[2] = 32'hBFFF_FFFF;
    send(29'h0000_0123, 1'b0, 1'b0, "R5 ide masked");

    // R6: dual standard
    idle(1);
    clear_table();
    fmt_sel = 2'b01;
    filt[2] = 32'hFFFF_05A5;
    send(29'h0000_05A5, 1'b0, 1'b0, "R6 std low half");
    send({11'h5A5, 18'h2_1234}, 1'b1, 1'b0, "R6 ext frame vs std filter");
    idle(1);
    msk[2] = 32'hFFFF_BFFF;
    send({11'h5A5, 18'h2_1234}, 1'b1, 1'b0, "R6 ext frame ide masked");
    // R9: overlap across words and inside a word, back to back
    idle(1);
    filt[1] = 32'h05A5_FFFF;
    filt[0] = 32'h0333_0333;
    send(29'h0000_05A5, 1'b0, 1'b0, "R9 across words");
    send(29'h0000_0333, 1'b0, 1'b0, "R9 inside word");

    // R7: quad slice
    idle(1);
    clear_table();
    fmt_sel = 2'b10;
    filt[6] = 32'hFFFF_3CFF;
    send(29'h0780_1234, 1'b1, 1'b1, "R7 slice ext");
    send(29'h0000_01E5, 1'b0, 1'b0, "R7 slice std");
    send(29'h0000_01F5, 1'b0, 1'b0, "R7 slice miss");
    // R8: off rejects the same frame
    idle(1);
    fmt_sel = 2'b11;
    send(29'h0780_1234, 1'b1, 1'b1, "R8 off");

    // random bursts: sparse masks give frequent multi-hits (R9, R2 back to back)
    for (int b = 0; b < 12; b++) begin
      idle(1);
      fmt_sel = 2'(b % 4);
      for (int k = 0; k < 8; k++) begin
        filt[k] = $urandom;
        msk[k]  = $urandom & $urandom & $urandom;
      end
      for (int n = 0; n < 25; n++)
        send(29'($urandom), 1'($urandom), 1'($urandom), "R9 random burst");
    end
    idle(4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule